// File: doc/BRIEF.md
# Pipelined Synchronous Burst Static RAM

This block is a synthesizable single-clock static RAM with a pipelined read path. Every control, address and data input is sampled on the rising clock edge into an input stage. The array access then happens on the following edge, and that same edge loads the output register. Read data therefore leaves the block two edges after its address was presented. A selected address strobe opens a burst. An advance input then walks the two low address bits through a group of four words, in either linear or interleaved order, and never leaves that aligned group.

Each cycle that carries an access is a read or a write, decided by the write enables of that cycle. A global write enable stores the full word. Otherwise a byte-write enable stores only the bytes whose individual enables are set. Three chip enables of mixed polarity must all be active for a strobe to select the device, which lets several instances share one address space. The output enable gates the data drive flag without waiting for a clock edge. A sleep input freezes the block without losing array contents or burst position.

Top module: `burst_sram`

## Requirements
- R1: After the asynchronous reset `data_oe_o` is 0, no burst is open, and an `adv_i` pulse without a prior strobe accesses nothing.
- R2: A read whose address is sampled at clock edge k presents the word on `rdata_o` with `data_oe_o` high after edge k+1, and only for that one cycle unless another read follows.
- R3: A strobe (`strobe_i`=1) is selected when `cs_a_i`=1, `cs_b_ni`=0 and `cs_c_ni`=0 all hold. It accesses `addr_i` and opens a burst. `adv_i`=1 without a strobe then accesses the next burst address. When both are high, the strobe wins.
- R4: `lin_order_i` is sampled with the strobe. When it is 1 (linear), the n-th access of the burst (n=0..3) uses low address bits (start + n) mod 4.
- R5: When the sampled `lin_order_i` is 0 (interleaved), the n-th access uses low address bits start XOR n.
- R6: A burst keeps address bits above bit 1 unchanged. After four accesses it wraps around to the starting word and continues in the same order.
- R7: `gw_i`=1 writes all bytes of `wdata_i`, whatever `bwe_i` and `be_i` are. Byte j is bits 8j+7 down to 8j.
- R8: When `gw_i`=0 and `bwe_i`=1, only byte j with `be_i[j]`=1 is written. If no byte is enabled, the access is a read.
- R9: A strobe with any chip enable inactive accesses nothing and closes the burst, so later `adv_i` pulses are ignored. `data_oe_o` is low after the next edge.
- R10: `data_oe_o` is the registered read-valid ANDed with `oe_i` combinationally, and `rdata_o` is 0 while it is low.
- R11: While `sleep_i`=1, strobes, advances and writes are ignored. Array contents and the burst position are kept, and the burst resumes after `sleep_i` returns to 0.
- R12: A read sampled one edge after a write to the same word returns the newly written bytes merged with the unwritten old bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Power-down request; freezes accesses |
| cs_a_i | input | 1 | Chip enable, active high |
| cs_b_ni | input | 1 | Chip enable, active low |
| cs_c_ni | input | 1 | Chip enable, active low |
| strobe_i | input | 1 | Address strobe; starts a burst |
| adv_i | input | 1 | Advance the burst counter |
| lin_order_i | input | 1 | Burst order for the next strobe: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | Word address |
| gw_i | input | 1 | Global write, full word |
| bwe_i | input | 1 | Byte-write enable |
| be_i | input | WORD_W/8 | Per-byte write enables |
| wdata_i | input | WORD_W | Write data |
| oe_i | input | 1 | Output enable, combinational |
| rdata_o | output | WORD_W | Read data, 0 when not driven |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
On every cycle the embedded properties check four things. Sleep never lets a request into the input stage. A deselecting strobe leaves the bus undriven two edges later. A global write always produces a full byte mask. Each advance stays inside its aligned group of four and, in linear order, steps the low bits by one. The interleaved sequence, byte merging, read-after-write, the reset state, the combinational output enable and retention across sleep are visible only through data values. The bench's scenarios compare those against a byte-masked reference array.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int unsigned BYTE_W = 8;

  // low two address bits of the n-th beat of a burst
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       lin);
    beat_low = lin ? (start + n) : (start ^ n);
  endfunction
endpackage

// File: rtl/burst_ctr.sv
module burst_ctr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              kill_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              lin_i,
  output logic              go_o,
  output logic              lin_o,
  output logic [ADDR_W-1:0] addr_o
);
  import burst_sram_pkg::*;

  logic              act_q;
  logic              lin_q;
  logic [1:0]        cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_nxt;

  assign go_o    = step_i & act_q;
  assign lin_o   = lin_q;
  assign cnt_nxt = cnt_q + 2'd1;
  assign addr_o  = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_nxt, lin_q)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      lin_q  <= 1'b1;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (load_i) begin
      act_q  <= 1'b1;
      lin_q  <= lin_i;
      cnt_q  <= '0;
      base_q <= load_addr_i;
    end else if (kill_i) begin
      act_q <= 1'b0;
    end else if (go_o) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic                         clk_i,
  input  logic                         en_i,
  input  logic [WORD_W/8-1:0]          mask_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [WORD_W-1:0]            rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned NB    = WORD_W / 8;

  logic [WORD_W-1:0] mem_q [DEPTH];

  // reads return the word before this edge's write; masks are never mixed with reads
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (mask_i == '0) begin
        rdata_o <= mem_q[addr_i];
      end else begin
        for (int j = 0; j < NB; j++) begin
          if (mask_i[j]) mem_q[addr_i][j*8 +: 8] <= wdata_i[j*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              oe_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= rd_i;
  end

  assign drive_o = vld_q & oe_i;
  assign rdata_o = drive_o ? rdata_i : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_i,
  input  logic                cs_a_i,
  input  logic                cs_b_ni,
  input  logic                cs_c_ni,
  input  logic                strobe_i,
  input  logic                adv_i,
  input  logic                lin_order_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                gw_i,
  input  logic                bwe_i,
  input  logic [WORD_W/8-1:0] be_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                oe_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic                data_oe_o
);
  localparam int unsigned NB = WORD_W / 8;

  logic              sel, awake, load, kill, step_req, go, acc_vld, lin_cur;
  logic [ADDR_W-1:0] burst_addr, acc_addr;
  logic [NB-1:0]     acc_mask;

  logic              req_vld_q;
  logic [NB-1:0]     req_mask_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_data_q;
  logic [WORD_W-1:0] arr_rdata;
  logic              rd_req;

  assign sel      = cs_a_i & ~cs_b_ni & ~cs_c_ni;
  assign awake    = ~sleep_i;
  assign load     = awake & strobe_i & sel;
  assign kill     = awake & strobe_i & ~sel;
  assign step_req = awake & ~strobe_i & adv_i;

  burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .kill_i      (kill),
    .step_i      (step_req),
    .load_addr_i (addr_i),
    .lin_i       (lin_order_i),
    .go_o        (go),
    .lin_o       (lin_cur),
    .addr_o      (burst_addr)
  );

  assign acc_vld  = load | go;
  assign acc_addr = load ? addr_i : burst_addr;
  assign acc_mask = gw_i ? {NB{1'b1}} : (bwe_i ? be_i : '0);

  // input stage: address, mask and data held while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_vld_q  <= 1'b0;
      req_mask_q <= '0;
      req_addr_q <= '0;
      req_data_q <= '0;
    end else begin
      req_vld_q <= acc_vld;
      if (acc_vld) begin
        req_mask_q <= acc_mask;
        req_addr_q <= acc_addr;
        req_data_q <= wdata_i;
      end
    end
  end

  assign rd_req = req_vld_q & (req_mask_q == '0);

  sram_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
    .clk_i   (clk_i),
    .en_i    (req_vld_q),
    .mask_i  (req_mask_q),
    .addr_i  (req_addr_q),
    .wdata_i (req_data_q),
    .rdata_o (arr_rdata)
  );

  out_stage #(.WORD_W(WORD_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_req),
    .oe_i    (oe_i),
    .rdata_i (arr_rdata),
    .rdata_o (rdata_o),
    .drive_o (data_oe_o)
  );

  AST_SLEEP_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !req_vld_q); // R11
  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> ##1 !data_oe_o); // R9
  AST_GW_FULL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld && gw_i) |=> (req_mask_q == {NB{1'b1}})); // R7
  AST_GROUP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (req_addr_q[ADDR_W-1:2] == $past(req_addr_q[ADDR_W-1:2]))); // R6
  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && lin_cur) |=> (req_addr_q[1:0] == $past(req_addr_q[1:0]) + 2'd1)); // R4
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WW = 32;
  localparam int NB = WW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 0, cs_a_i = 1, cs_b_ni = 0, cs_c_ni = 0;
  logic strobe_i = 0, adv_i = 0, lin_order_i = 1;
  logic [AW-1:0] addr_i = '0;
  logic gw_i = 0, bwe_i = 0;
  logic [NB-1:0] be_i = '0;
  logic [WW-1:0] wdata_i = '0;
  logic oe_i = 1;
  logic [WW-1:0] rdata_o;
  logic data_oe_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference model
  logic [WW-1:0] ref_mem [DEPTH];
  logic p_vld = 0; logic [NB-1:0] p_mask = '0; logic [AW-1:0] p_addr = '0; logic [WW-1:0] p_data = '0;
  logic e_vld = 0; logic [WW-1:0] e_data = '0;
  logic b_act = 0, b_lin = 1; logic [1:0] b_cnt = 0; logic [AW-1:0] b_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .WORD_W(WW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .cs_a_i(cs_a_i), .cs_b_ni(cs_b_ni),
    .cs_c_ni(cs_c_ni), .strobe_i(strobe_i), .adv_i(adv_i), .lin_order_i(lin_order_i),
    .addr_i(addr_i), .gw_i(gw_i), .bwe_i(bwe_i), .be_i(be_i), .wdata_i(wdata_i),
    .oe_i(oe_i), .rdata_o(rdata_o), .data_oe_o(data_oe_o));

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, logic [1:0] n, logic lin);
    logic [1:0] lo;
    lo = lin ? base[1:0] + n : base[1:0] ^ n;
    return {base[AW-1:2], lo};
  endfunction

  function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw, logic [NB-1:0] m);
    logic [WW-1:0] r;
    r = old;
    for (int j = 0; j < NB; j++) if (m[j]) r[j*8 +: 8] = nw[j*8 +: 8];
    return r;
  endfunction

  task automatic check(string t, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic model_edge();
    logic sel, awake;
    logic [AW-1:0] a;
    e_vld = p_vld && (p_mask == '0);
    if (e_vld) e_data = ref_mem[p_addr];
    if (p_vld && p_mask != '0) ref_mem[p_addr] = merge(ref_mem[p_addr], p_data, p_mask);
    sel = cs_a_i && !cs_b_ni && !cs_c_ni;
    awake = !sleep_i;
    p_vld = 0;
    if (awake && strobe_i && sel) begin
      b_act = 1; b_base = addr_i; b_cnt = 0; b_lin = lin_order_i;
      a = addr_i; p_vld = 1;
    end else if (awake && strobe_i) begin
      b_act = 0;
    end else if (awake && adv_i && b_act) begin
      b_cnt = b_cnt + 2'd1;
      a = beat_addr(b_base, b_cnt, b_lin); p_vld = 1;
    end
    if (p_vld) begin
      p_addr = a; p_data = wdata_i;
      p_mask = gw_i ? {NB{1'b1}} : (bwe_i ? be_i : '0);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({tag, " drive"}, {{(WW-1){1'b0}}, data_oe_o}, {{(WW-1){1'b0}}, e_vld && oe_i});
    if (e_vld && oe_i) check({tag, " data"}, rdata_o, e_data);
    strobe_i = 0; adv_i = 0; gw_i = 0; bwe_i = 0; be_i = '0;
  endtask

  task automatic strobe(logic [AW-1:0] a, logic lin);
    strobe_i = 1; addr_i = a; lin_order_i = lin; cyc();
  endtask

  task automatic wr_full(logic [AW-1:0] a, logic [WW-1:0] d);
    strobe_i = 1; addr_i = a; gw_i = 1; wdata_i = d; cyc();
  endtask

  task automatic advance(int k);
    for (int i = 0; i < k; i++) begin adv_i = 1; cyc(); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state and stray advance
    check("R1 reset drive", {{(WW-1){1'b0}}, data_oe_o}, '0);
    tag = "R1"; advance(2); cyc();
    // R7 fill via global write; be/bwe set but ignored
    tag = "R7";
    for (int i = 0; i < 16; i++) begin bwe_i = 1; be_i = 4'h1; wr_full(AW'(i), 32'hA5000000 + 32'(i * 32'h01010101)); end
    cyc();
    // R2 single read latency
    tag = "R2"; strobe(8'd5, 1); cyc(); cyc();
    // R4 linear from 6, plus R6 wrap
    tag = "R4 R6 linear"; strobe(8'd6, 1); advance(6); cyc();
    // R5 interleaved from 9
    tag = "R5 interleaved"; strobe(8'd9, 0); advance(5); cyc();
    // R3 strobe priority over adv
    tag = "R3"; strobe_i = 1; adv_i = 1; addr_i = 8'd2; lin_order_i = 1; cyc(); advance(1); cyc();
    // R8 byte writes then R12 read right after
    tag = "R8 R12";
    strobe_i = 1; addr_i = 8'd3; bwe_i = 1; be_i = 4'b0101; wdata_i = 32'h11223344; cyc();
    strobe(8'd3, 1); cyc();
    strobe_i = 1; addr_i = 8'd4; bwe_i = 1; be_i = 4'b1000; wdata_i = 32'hDEADBEEF; cyc();
    strobe(8'd4, 1);
    strobe_i = 1; addr_i = 8'd4; bwe_i = 1; be_i = 4'b0000; wdata_i = 32'h0; cyc(); cyc(); cyc();
    // R9 deselect on each enable, then adv ignored
    tag = "R9";
    strobe(8'd1, 1); cs_a_i = 0; strobe(8'd7, 1); cs_a_i = 1; advance(2);
    strobe(8'd1, 1); cs_b_ni = 1; strobe(8'd7, 1); cs_b_ni = 0; advance(1);
    strobe(8'd1, 1); cs_c_ni = 1; strobe(8'd7, 1); cs_c_ni = 0; advance(1); cyc();
    // R10 asynchronous output enable
    tag = "R10"; strobe(8'd2, 1);
    @(posedge clk); model_edge(); @(negedge clk);
    oe_i = 0; #1;
    check("R10 oe low", {{(WW-1){1'b0}}, data_oe_o}, '0);
    check("R10 data zero", rdata_o, '0);
    oe_i = 1; #1;
    check("R10 oe high", {{(WW-1){1'b0}}, data_oe_o}, 1);
    check("R10 data", rdata_o, e_data);
    cyc();
    // R11 sleep: writes ignored, burst kept
    tag = "R11";
    strobe(8'd12, 1);
    sleep_i = 1; wr_full(8'd13, 32'h0BADF00D); advance(2); strobe(8'd40, 0); cyc();
    sleep_i = 0; advance(3); cyc(); strobe(8'd13, 1); cyc(); cyc();
    // random mix, seeded
    tag = "R2 random";
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin wr_full(AW'(i), $urandom()); end
    cyc();
    for (int i = 0; i < 4000; i++) begin
      strobe_i = ($urandom_range(9) < 3);
      adv_i = ($urandom_range(9) < 6);
      addr_i = AW'($urandom());
      lin_order_i = $urandom_range(1);
      gw_i = ($urandom_range(19) < 3);
      bwe_i = ($urandom_range(9) < 2);
      be_i = NB'($urandom());
      wdata_i = $urandom();
      cs_a_i = ($urandom_range(19) != 0);
      cs_b_ni = ($urandom_range(19) == 0);
      cs_c_ni = ($urandom_range(19) == 0);
      sleep_i = ($urandom_range(19) == 0);
      oe_i = ($urandom_range(9) != 0);
      cyc();
    end
    cs_a_i = 1; cs_b_ni = 0; cs_c_ni = 0; sleep_i = 0; oe_i = 1;
    cyc(); cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule